// File: doc/BRIEF.md
# EDID Boot Loader with Hot-Plug Holdoff

This block fills a 256-byte EDID store after power-up, after a qualified restart request, or after the first hot-plug event. In the default mode it works as a byte-level read master. It sends commands to a separate bit-level I2C engine over a simple command/response link and copies an external EEPROM into the store. The four per-port hot-plug outputs are held low from reset until a copy has completed and a follow-on descriptor scan has finished. Sources therefore never see a sink that has no descriptor data.

A host can take over the store through a mode register. Once the master is parked, the host writes bytes through the configuration port using the EEPROM device address. Clearing the mode register gives the store back to the master, which then copies the EEPROM again. A global enable input switches the whole feature off, so the hot-plug outputs follow their requests directly. When the EEPROM refuses an address byte, the copy is aborted, an error flag is raised and the copy is retried after a fixed back-off.

Top module: `edid_boot_loader`

## Requirements
- R1: After `rst_n` releases with `repl_en` high, the block issues exactly this command order on `cmd_op` (0 start, 1 write, 2 read, 3 stop): start with byte 0xA0, write with byte 0x00, start with byte 0xA1, then 256 reads, then a stop. `cmd_last` is high on the final read only.
- R2: While a copy is pending or running, and until `scan_done`, every bit of `hpd_out` is 0. After that, `hpd_out` equals `hpd_in`.
- R3: Each byte returned for the n-th read is stored at address n. `rd_data` shows the byte at `rd_addr` one clock later.
- R4: The first rising edge on any bit of `hpd_in` after reset starts one more copy. Later rising edges start no copy.
- R5: `restart_n` low starts a new copy only while `supply_ok` is high. When `supply_ok` is low it has no effect.
- R6: While `repl_en` is low, no command is issued and `hpd_out` equals `hpd_in`. A request seen in that time is served once `repl_en` returns high.
- R7: A configuration write to device 0x90, register 0x0E, with a nonzero byte parks the master: no commands are issued and the hold is released. Writing 0x00 there while the master is parked starts a new copy.
- R8: A configuration write to device 0xA0 stores `cfg_wdata` at `cfg_addr` only while the master is parked. In the default mode it changes nothing.
- R9: A refused (`rsp_ack` low) start or write is followed by a stop. The block then raises `copy_err`, waits at least 64 cycles and retries from the first start, with `hpd_out` still low. A successful copy clears `copy_err`.
- R10: `copy_done` rises after the last byte is stored, together with a one-cycle `scan_start` pulse. The hold stays on until `scan_done`.
- R11: At most one command is outstanding. `cmd_valid` is never high on two consecutive cycles and is never high again before `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| repl_en | input | 1 | Feature enable |
| supply_ok | input | 1 | Local supply good, qualifies restart |
| restart_n | input | 1 | Active-low copy restart request |
| hpd_in | input | 4 | Requested hot-plug levels per port |
| hpd_out | output | 4 | Gated hot-plug outputs |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_dev | input | 8 | Configuration device address |
| cfg_addr | input | 8 | Register or store address |
| cfg_wdata | input | 8 | Configuration write data |
| cmd_valid | output | 1 | Command strobe to the bit engine |
| cmd_op | output | 2 | 0 start, 1 write, 2 read, 3 stop |
| cmd_byte | output | 8 | Byte sent with start or write |
| cmd_last | output | 1 | Read without acknowledge (final byte) |
| rsp_valid | input | 1 | Response strobe from the bit engine |
| rsp_ack | input | 1 | Acknowledge seen for start/write |
| rsp_data | input | 8 | Byte received by a read |
| scan_start | output | 1 | One-cycle pulse starting the descriptor scan |
| scan_done | input | 1 | Descriptor scan finished |
| rd_addr | input | 8 | Store read address |
| rd_data | output | 8 | Store read data, one cycle latency |
| copy_done | output | 1 | Last copy completed |
| copy_err | output | 1 | Last attempt refused by the EEPROM |

## Verification
The bench models the EEPROM and the bit engine with random response delays and random contents, and it checks the command order byte by byte. A design that flags the wrong read as final or skips the word-address write is caught there. Refused start bytes are injected twice in a row, so a design that drops the hold during back-off, retries too early or leaves `copy_err` set after success is reported. Qualified and unqualified restarts, a repeated hot-plug edge and a disabled feature each check `hpd_out` against `hpd_in`, which exposes an ungated restart or a trigger that re-arms. Host writes are tried in both modes and read back, so a store that accepts host bytes in the default mode, or that the re-enabled copy fails to overwrite, is reported.

// File: rtl/edid_boot_pkg.sv
// Package: shared encodings for the EDID boot loader.
// Assumes: the bit-level engine decodes cmd_op with the codes below.
package edid_boot_pkg;
    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_STOP  = 2'd3
    } i2c_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_BACKOFF,
        ST_SCAN
    } seq_state_e;

    typedef enum logic [2:0] {
        PH_DEV_W,
        PH_WORD,
        PH_DEV_R,
        PH_READ,
        PH_STOP
    } phase_e;
endpackage

// File: rtl/edid_trigger.sv
// Module: edid_trigger
// Collects copy requests (reset, qualified restart, first hot-plug rise,
// re-enable from host mode) into one pending flag that the sequencer consumes.
// Assumes: launch is a one-cycle acknowledge from the sequencer.
module edid_trigger #(
    parameter int PORTS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_n,
    input  logic             supply_ok,
    input  logic [PORTS-1:0] hpd_in,
    input  logic             reenable,
    input  logic             launch,
    output logic             pending,
    output logic             abort
);
    logic [PORTS-1:0] hpd_prev_q;
    logic             armed_q;
    logic             pend_q;
    logic             hp_rise;

    // restart honoured only with a good local supply
    assign abort   = !restart_n && supply_ok;
    assign hp_rise = armed_q && (|(hpd_in & ~hpd_prev_q));
    assign pending = pend_q;

    // request flag: set by any trigger, cleared when the copy launches
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q     <= 1'b1;
            armed_q    <= 1'b1;
            hpd_prev_q <= '0;
        end else begin
            hpd_prev_q <= hpd_in;
            if (hp_rise) armed_q <= 1'b0;
            if (abort || hp_rise || reenable) pend_q <= 1'b1;
            else if (launch)                  pend_q <= 1'b0;
        end
    end
endmodule

// File: rtl/edid_mode_ctrl.sv
// Module: edid_mode_ctrl
// Decodes configuration writes: the mode register that parks the master and
// host writes into the EDID store at the EEPROM device address.
// Assumes: one write per cfg_we cycle.
module edid_mode_ctrl #(
    parameter logic [7:0] CTRL_DEV = 8'h90,
    parameter logic [7:0] MODE_REG = 8'h0E,
    parameter logic [7:0] RAM_DEV  = 8'hA0,
    parameter int         ADDR_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_dev,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [7:0]        cfg_wdata,
    output logic              master_off,
    output logic              reenable,
    output logic              host_we
);
    logic off_q;
    logic reen_q;
    logic mode_hit;

    assign mode_hit   = cfg_we && (cfg_dev == CTRL_DEV) && (cfg_addr == ADDR_W'(MODE_REG));
    assign master_off = off_q;
    assign reenable   = reen_q;
    // host bytes reach the store only while the master is parked
    assign host_we    = cfg_we && (cfg_dev == RAM_DEV) && off_q;

    // mode register and one-cycle re-enable pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_q  <= 1'b0;
            reen_q <= 1'b0;
        end else begin
            reen_q <= 1'b0;
            if (mode_hit) begin
                off_q  <= (cfg_wdata != 8'h00);
                reen_q <= off_q && (cfg_wdata == 8'h00);
            end
        end
    end
endmodule

// File: rtl/edid_ram.sv
// Module: edid_ram
// EDID store with one write port shared by master and host and a registered
// read port for the downstream per-port readers.
// Assumes: master and host never write in the same cycle.
module edid_ram #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              mst_we,
    input  logic [ADDR_W-1:0] mst_addr,
    input  logic [7:0]        mst_data,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [7:0]        host_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem_q [DEPTH];

    // single write port, host selected when it writes
    always_ff @(posedge clk) begin
        if (host_we)     mem_q[host_addr] <= host_data;
        else if (mst_we) mem_q[mst_addr]  <= mst_data;
    end

    // registered read
    always_ff @(posedge clk) begin
        rd_data <= mem_q[rd_addr];
    end
endmodule

// File: rtl/edid_copy_seq.sv
// Module: edid_copy_seq
// Byte-level read master: random read at word 0, sequential read of the whole
// store, stop, then a scan handshake. Refusals lead to stop, error and back-off.
// Assumes: the bit engine answers each command with exactly one rsp_valid.
module edid_copy_seq
    import edid_boot_pkg::*;
#(
    parameter int         ADDR_W         = 8,
    parameter int         BACKOFF_CYCLES = 64,
    parameter logic [7:0] DEV_ADDR       = 8'hA0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              abort,
    input  logic              pending,
    output logic              launch,
    output logic              cmd_valid,
    output logic [1:0]        cmd_op,
    output logic [7:0]        cmd_byte,
    output logic              cmd_last,
    input  logic              rsp_valid,
    input  logic              rsp_ack,
    input  logic [7:0]        rsp_data,
    output logic              scan_start,
    input  logic              scan_done,
    output logic              busy,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              copy_done,
    output logic              copy_err
);
    localparam int                CNT_W    = $clog2(BACKOFF_CYCLES + 1);
    localparam logic [ADDR_W-1:0] LAST_IDX = '1;

    seq_state_e        state_q;
    phase_e            phase_q;
    logic [ADDR_W-1:0] idx_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              fail_q;
    logic              done_q;
    logic              err_q;
    logic              scan_q;
    i2c_op_e           op;

    assign launch     = active && !abort && (state_q == ST_IDLE) && pending;
    assign busy       = (state_q != ST_IDLE);
    assign cmd_valid  = (state_q == ST_ISSUE);
    assign cmd_last   = (phase_q == PH_READ) && (idx_q == LAST_IDX);
    assign cmd_op     = op;
    assign wr_en      = active && !abort && (state_q == ST_WAIT) && rsp_valid && (phase_q == PH_READ);
    assign wr_addr    = idx_q;
    assign wr_data    = rsp_data;
    assign copy_done  = done_q;
    assign copy_err   = err_q;
    assign scan_start = scan_q;

    // command decode from the current phase
    always_comb begin
        unique case (phase_q)
            PH_DEV_W: begin op = OP_START; cmd_byte = DEV_ADDR;        end
            PH_WORD:  begin op = OP_WRITE; cmd_byte = 8'h00;           end
            PH_DEV_R: begin op = OP_START; cmd_byte = DEV_ADDR | 8'h01; end
            PH_READ:  begin op = OP_READ;  cmd_byte = 8'h00;           end
            default:  begin op = OP_STOP;  cmd_byte = 8'h00;           end
        endcase
    end

    // copy state machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            phase_q <= PH_DEV_W;
            idx_q   <= '0;
            cnt_q   <= '0;
            fail_q  <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            scan_q  <= 1'b0;
        end else begin
            scan_q <= 1'b0;
            if (!active || abort) begin
                state_q <= ST_IDLE;
            end else begin
                unique case (state_q)
                    ST_IDLE: if (pending) begin
                        state_q <= ST_ISSUE;
                        phase_q <= PH_DEV_W;
                        idx_q   <= '0;
                        fail_q  <= 1'b0;
                        done_q  <= 1'b0;
                    end
                    ST_ISSUE: state_q <= ST_WAIT;
                    ST_WAIT: if (rsp_valid) begin
                        state_q <= ST_ISSUE;
                        unique case (phase_q)
                            PH_DEV_W, PH_WORD, PH_DEV_R: begin
                                if (!rsp_ack) begin
                                    fail_q  <= 1'b1;
                                    phase_q <= PH_STOP;
                                end else if (phase_q == PH_DEV_W) phase_q <= PH_WORD;
                                else if (phase_q == PH_WORD)      phase_q <= PH_DEV_R;
                                else                              phase_q <= PH_READ;
                            end
                            PH_READ: begin
                                if (idx_q == LAST_IDX) phase_q <= PH_STOP;
                                else                   idx_q   <= idx_q + 1'b1;
                            end
                            default: begin
                                if (fail_q) begin
                                    err_q   <= 1'b1;
                                    cnt_q   <= '0;
                                    state_q <= ST_BACKOFF;
                                end else begin
                                    err_q   <= 1'b0;
                                    done_q  <= 1'b1;
                                    scan_q  <= 1'b1;
                                    state_q <= ST_SCAN;
                                end
                            end
                        endcase
                    end
                    ST_BACKOFF: begin
                        if (cnt_q == CNT_W'(BACKOFF_CYCLES - 1)) begin
                            state_q <= ST_ISSUE;
                            phase_q <= PH_DEV_W;
                            idx_q   <= '0;
                            fail_q  <= 1'b0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    ST_SCAN: if (scan_done) state_q <= ST_IDLE;
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    // R11: one command at a time
    assert_single_cmd_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);
    // R6: nothing issued once the feature was off or parked
    assert_quiet_when_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(active) |-> !cmd_valid);
    // R9: a completed copy never reports an error
    assert_err_clear_on_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(copy_done) |-> !copy_err);
    // R10: scan start is a single-cycle pulse
    assert_scan_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        scan_start |=> !scan_start);
endmodule

// File: rtl/edid_boot_loader.sv
// Module: edid_boot_loader (top)
// Fills the EDID store from an EEPROM or lets a host write it, and holds all
// hot-plug outputs low while a copy is pending or running.
// Assumes: restart and mode changes are applied while no copy is in flight.
module edid_boot_loader #(
    parameter int         PORTS          = 4,
    parameter int         ADDR_W         = 8,
    parameter int         BACKOFF_CYCLES = 64,
    parameter logic [7:0] CTRL_DEV       = 8'h90,
    parameter logic [7:0] MODE_REG       = 8'h0E,
    parameter logic [7:0] RAM_DEV        = 8'hA0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              repl_en,
    input  logic              supply_ok,
    input  logic              restart_n,
    input  logic [PORTS-1:0]  hpd_in,
    output logic [PORTS-1:0]  hpd_out,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_dev,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [7:0]        cfg_wdata,
    output logic              cmd_valid,
    output logic [1:0]        cmd_op,
    output logic [7:0]        cmd_byte,
    output logic              cmd_last,
    input  logic              rsp_valid,
    input  logic              rsp_ack,
    input  logic [7:0]        rsp_data,
    output logic              scan_start,
    input  logic              scan_done,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              copy_done,
    output logic              copy_err
);
    logic              master_off;
    logic              reenable;
    logic              host_we;
    logic              pending;
    logic              abort;
    logic              launch;
    logic              busy;
    logic              active;
    logic              hold;
    logic              seq_we;
    logic [ADDR_W-1:0] seq_addr;
    logic [7:0]        seq_data;

    assign active  = repl_en && !master_off;
    assign hold    = active && (pending || busy);
    // hot-plug gate: all ports low while the store is not valid
    assign hpd_out = hold ? '0 : hpd_in;

    edid_mode_ctrl #(
        .CTRL_DEV (CTRL_DEV),
        .MODE_REG (MODE_REG),
        .RAM_DEV  (RAM_DEV),
        .ADDR_W   (ADDR_W)
    ) mode_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_dev    (cfg_dev),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .master_off (master_off),
        .reenable   (reenable),
        .host_we    (host_we)
    );

    edid_trigger #(.PORTS(PORTS)) trig_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_n (restart_n),
        .supply_ok (supply_ok),
        .hpd_in    (hpd_in),
        .reenable  (reenable),
        .launch    (launch),
        .pending   (pending),
        .abort     (abort)
    );

    edid_copy_seq #(
        .ADDR_W         (ADDR_W),
        .BACKOFF_CYCLES (BACKOFF_CYCLES),
        .DEV_ADDR       (RAM_DEV)
    ) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (active),
        .abort      (abort),
        .pending    (pending),
        .launch     (launch),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .cmd_byte   (cmd_byte),
        .cmd_last   (cmd_last),
        .rsp_valid  (rsp_valid),
        .rsp_ack    (rsp_ack),
        .rsp_data   (rsp_data),
        .scan_start (scan_start),
        .scan_done  (scan_done),
        .busy       (busy),
        .wr_en      (seq_we),
        .wr_addr    (seq_addr),
        .wr_data    (seq_data),
        .copy_done  (copy_done),
        .copy_err   (copy_err)
    );

    edid_ram #(.ADDR_W(ADDR_W)) ram_i (
        .clk       (clk),
        .mst_we    (seq_we),
        .mst_addr  (seq_addr),
        .mst_data  (seq_data),
        .host_we   (host_we),
        .host_addr (cfg_addr),
        .host_data (cfg_wdata),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data)
    );

    // R2: no port sees hot-plug while an enabled copy is in progress
    assert_hold_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && active) |-> (hpd_out == '0));
    // R8: master and host never write the store together
    assert_one_writer_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(seq_we && host_we));
endmodule

// File: tb/edid_boot_loader_tb.sv
module edid_boot_loader_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int BACKOFF    = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       repl_en = 1'b1, supply_ok = 1'b1, restart_n = 1'b1;
    logic [3:0] hpd_in = 4'h0;
    logic [3:0] hpd_out;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_dev = 8'h00, cfg_addr = 8'h00, cfg_wdata = 8'h00;
    logic       cmd_valid, cmd_last;
    logic [1:0] cmd_op;
    logic [7:0] cmd_byte;
    logic       rsp_valid = 1'b0, rsp_ack = 1'b0;
    logic [7:0] rsp_data = 8'h00;
    logic       scan_start;
    logic       scan_done = 1'b0;
    logic [7:0] rd_addr = 8'h00;
    logic [7:0] rd_data;
    logic       copy_done, copy_err;

    int checks = 0, errors = 0, cyc = 0;
    int cmd_count = 0, copies_ok = 0, seq_err = 0, nak_starts = 0, nak_seen = 0;
    int scan_pulses = 0, min_gap = 1000000, stop_cyc = 0;
    int rcnt = 0, step = 0, ptr = 0, scnt = 0;
    bit fail_pend = 0, gap_armed = 0;
    logic [7:0] eep [256];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc++;

    edid_boot_loader dut_i (
        .clk(clk), .rst_n(rst_n), .repl_en(repl_en), .supply_ok(supply_ok),
        .restart_n(restart_n), .hpd_in(hpd_in), .hpd_out(hpd_out),
        .cfg_we(cfg_we), .cfg_dev(cfg_dev), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_byte(cmd_byte), .cmd_last(cmd_last),
        .rsp_valid(rsp_valid), .rsp_ack(rsp_ack), .rsp_data(rsp_data),
        .scan_start(scan_start), .scan_done(scan_done),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .copy_done(copy_done), .copy_err(copy_err)
    );

    // EEPROM + bit engine + scan model; tracks the expected command order (R1, R9, R11)
    always @(negedge clk) begin
        rsp_valid = 1'b0;
        scan_done = 1'b0;
        if (!rst_n) begin
            rcnt = 0; step = 0;
        end else begin
            if (rcnt > 0) begin
                rcnt--;
                if (rcnt == 0) rsp_valid = 1'b1;
            end
            if (cmd_valid) begin
                cmd_count++;
                if (rcnt != 0) seq_err++;
                rcnt = 1 + int'($urandom % 3);
                rsp_ack = 1'b1; rsp_data = 8'h00;
                case (cmd_op)
                    2'd0: begin
                        if (step == 0 && cmd_byte == 8'hA0) begin
                            if (gap_armed) begin
                                if (cyc - stop_cyc < min_gap) min_gap = cyc - stop_cyc;
                                gap_armed = 0;
                            end
                            if (nak_starts > 0) begin
                                nak_starts--; nak_seen++; rsp_ack = 1'b0;
                                fail_pend = 1; step = 4;
                            end else step = 1;
                        end else if (step == 2 && cmd_byte == 8'hA1) step = 3;
                        else seq_err++;
                    end
                    2'd1: begin
                        if (step == 1 && cmd_byte == 8'h00) begin step = 2; ptr = 0; end
                        else seq_err++;
                    end
                    2'd2: begin
                        if (step == 3) begin
                            rsp_data = eep[ptr & 255];
                            if (cmd_last != (ptr == 255)) seq_err++;
                            if (ptr == 255) step = 4;
                            ptr++;
                        end else seq_err++;
                    end
                    default: begin
                        if (step == 4) begin
                            if (fail_pend) begin gap_armed = 1; stop_cyc = cyc; fail_pend = 0; end
                            else copies_ok++;
                            step = 0;
                        end else seq_err++;
                    end
                endcase
            end
            if (scnt > 0) begin
                scnt--;
                if (scnt == 0) scan_done = 1'b1;
            end
            if (scan_start) begin scan_pulses++; scnt = 4; end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_copies(input int target);
        while (copies_ok < target) tick(1);
        tick(12);
    endtask

    task automatic cfg_write(input logic [7:0] dev, input logic [7:0] a, input logic [7:0] d);
        cfg_we = 1'b1; cfg_dev = dev; cfg_addr = a; cfg_wdata = d;
        tick(1);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        rd_addr = a;
        tick(1);
        d = rd_data;
    endtask

    function automatic logic [7:0] rnd_byte();
        return 8'($urandom);
    endfunction

    task automatic fill_eep();
        for (int i = 0; i < 256; i++) eep[i] = rnd_byte();
    endtask

    // compare whole store against the model; returns mismatch count
    task automatic store_mismatch(output int bad);
        logic [7:0] v;
        bad = 0;
        for (int i = 0; i < 256; i++) begin
            rd(8'(i), v);
            if (v !== eep[i]) bad++;
        end
    endtask

    task automatic pulse_restart();
        restart_n = 1'b0; tick(3); restart_n = 1'b1;
    endtask

    // watchdog
    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int bad, cc, cp;
        logic [7:0] v;
        logic [7:0] hd [8];
        logic [7:0] ha [8];
        void'($urandom(32'd2024));
        fill_eep();
        tick(4);
        // R2: outputs low and flags clear right after reset
        check(hpd_out == 4'h0 && !copy_done && !copy_err, "R2 reset state", hpd_out, 0);
        rst_n = 1'b1;
        wait_copies(1);
        check(copies_ok == 1 && seq_err == 0, "R1 power-up command order", seq_err, 0);
        store_mismatch(bad);
        check(bad == 0, "R3 store equals EEPROM", bad, 0);
        check(copy_done && scan_pulses == 1, "R10 done flag and one scan pulse", scan_pulses, 1);

        // R4: first hot-plug rise starts a copy with hold
        hpd_in = 4'b0101;
        tick(4);
        check(hpd_out == 4'h0, "R2 hold during hot-plug copy", hpd_out, 0);
        wait_copies(2);
        check(copies_ok == 2, "R4 first hot-plug copy", copies_ok, 2);
        check(hpd_out == 4'b0101, "R2 release after scan", hpd_out, 5);
        hpd_in = 4'b0000; tick(3); hpd_in = 4'b1010; tick(20);
        check(copies_ok == 2 && hpd_out == 4'b1010, "R4 later rise ignored", hpd_out, 10);

        // R5: restart ignored without supply, honoured with it
        fill_eep();
        cc = cmd_count;
        supply_ok = 1'b0; pulse_restart(); tick(20);
        check(cmd_count == cc && hpd_out == 4'b1010 && copy_done, "R5 restart ignored", cmd_count - cc, 0);
        supply_ok = 1'b1; pulse_restart(); tick(3);
        check(hpd_out == 4'h0, "R5 restart holds hot-plug", hpd_out, 0);
        wait_copies(3);
        store_mismatch(bad);
        check(bad == 0 && seq_err == 0, "R5 restart copies new contents", bad, 0);

        // R9: two refusals, back-off, then success
        nak_starts = 2;
        pulse_restart();
        while (nak_seen < 1) tick(1);
        tick(10);
        check(copy_err && hpd_out == 4'h0, "R9 error and hold during back-off", copy_err, 1);
        wait_copies(4);
        check(!copy_err && nak_seen == 2 && seq_err == 0, "R9 retry succeeds and clears error", copy_err, 0);
        check(min_gap >= BACKOFF, "R9 back-off length", min_gap, BACKOFF);

        // R6: feature disabled
        repl_en = 1'b0; tick(2);
        check(hpd_out == hpd_in, "R6 pass-through when disabled", hpd_out, hpd_in);
        cc = cmd_count;
        pulse_restart(); tick(30);
        check(cmd_count == cc && hpd_out == hpd_in, "R6 no commands when disabled", cmd_count - cc, 0);
        cp = copies_ok;
        repl_en = 1'b1;
        wait_copies(cp + 1);
        check(copies_ok == cp + 1, "R6 held request served", copies_ok, cp + 1);

        // R8: host write ignored in default mode
        cfg_write(8'hA0, 8'h05, ~eep[5]);
        rd(8'h05, v);
        check(v == eep[5], "R8 host write ignored", v, eep[5]);

        // R7: park the master
        cfg_write(8'h90, 8'h0E, 8'h01);
        cc = cmd_count;
        tick(2);
        check(hpd_out == hpd_in, "R7 parked releases hold", hpd_out, hpd_in);
        for (int k = 0; k < 8; k++) begin
            ha[k] = rnd_byte();
            for (int j = 0; j < k; j++) if (ha[j] == ha[k]) ha[k] = ha[k] + 8'd1;
            hd[k] = ~eep[ha[k]];
            cfg_write(8'hA0, ha[k], hd[k]);
        end
        bad = 0;
        for (int k = 0; k < 8; k++) begin
            rd(ha[k], v);
            if (v !== hd[k]) bad++;
        end
        check(bad == 0, "R8 host writes stored while parked", bad, 0);
        tick(20);
        check(cmd_count == cc, "R7 no commands while parked", cmd_count - cc, 0);
        cp = copies_ok;
        cfg_write(8'h90, 8'h0E, 8'h00);
        tick(4);
        check(hpd_out == 4'h0, "R7 re-enable holds hot-plug", hpd_out, 0);
        wait_copies(cp + 1);
        store_mismatch(bad);
        check(bad == 0 && seq_err == 0, "R7 re-enable recopies store", bad, 0);
        check(scan_pulses == copies_ok, "R10 one scan per copy", scan_pulses, copies_ok);
        check(seq_err == 0, "R11 single outstanding command", seq_err, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule